// File: doc/BRIEF.md
# Little-Endian Load/Store Access Unit

This block carries out 64-bit integer load and store instructions against a data memory that is addressed in bytes and organised as aligned doublewords. It accepts one instruction word at a time, together with the value of the base register and, for stores, the value to write. It decodes the access width and the extension mode, forms the effective address, and drives a memory port that moves one aligned doubleword per transaction under byte enables. The least-significant byte of every value sits at the lowest address.

The offset is a signed 12-bit field. Loads keep it in one contiguous field. Stores keep it in two separate pieces, so the register fields stay in the same place in both formats. An access may start at any byte address. If all of its bytes fall inside one aligned doubleword, it needs one memory transaction. Otherwise the unit issues the lower doubleword first and the upper one next. For a load it then merges the bytes of both. This split costs one extra cycle and never raises a fault.

The memory port has a fixed latency: read data appears in the cycle after the transaction is issued. A finished load is presented for one cycle together with its destination register number. The unit takes a new request only when it is idle.

Top module: `lsu_top`

## Requirements
- R1: After reset, req_ready is 1, mem_req is 0 and ld_valid is 0.
- R2: A load has opcode bits [6:0] = 0000011. Its effective address is req_base plus the sign-extended 12-bit field in bits [31:20].
- R3: A store has opcode 0100011. Its offset is {insn[31:25], insn[11:7]}, sign-extended and added to req_base.
- R4: Funct3 bits [1:0] choose the width: 00 is 1 byte, 01 is 2, 10 is 4, 11 is 8. Byte i of the value is at effective address + i.
- R5: For loads, funct3 bit 2 = 0 sign-extends the loaded value to 64 bits and bit 2 = 1 zero-extends it.
- R6: An access that fits inside one aligned doubleword issues exactly one transaction, in the cycle after acceptance (cycle 1). A load result follows in cycle 3, and req_ready returns in cycle 3 for a load and in cycle 2 for a store.
- R7: An access that crosses a doubleword boundary issues two transactions in consecutive cycles: first the lower aligned address, then that address plus 8. The load result and the return of req_ready each move one cycle later than in R6.
- R8: A store writes exactly its own bytes. mem_be marks only those lanes, and every other memory byte keeps its value.
- R9: req_ready stays low from the cycle after acceptance until the access finishes. ld_valid is high for exactly one cycle per load.
- R10: An instruction with any other opcode, a load with funct3 = 111, or a store with funct3 bit 2 = 1 is accepted and does nothing: no transaction and no result.
- R11: The load result carries insn[11:7] on ld_rd.
- R12: mem_addr is always aligned to a doubleword (bits [2:0] = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Unit is idle and takes the request |
| req_insn | input | 32 | Instruction word |
| req_base | input | ADDR_W | Base register value |
| req_wdata | input | DATA_W | Store source value |
| mem_req | output | 1 | Memory transaction this cycle |
| mem_we | output | 1 | Transaction is a write |
| mem_addr | output | ADDR_W | Doubleword-aligned address |
| mem_be | output | DATA_W/8 | Byte lane enables for writes |
| mem_wdata | output | DATA_W | Write data, placed in lanes |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read |
| ld_valid | output | 1 | Load result valid (one cycle) |
| ld_rd | output | 5 | Destination register of the load |
| ld_data | output | DATA_W | Extended load result |

## Verification
The bench builds the unit with ADDR_W = 64 and DATA_W = 64, so the memory word is eight byte lanes. At this width the full range of funct3 is in play, including the doubleword and word-unsigned forms. Every start offset from 0 to 7 is reachable, so every way an access can straddle a boundary gets exercised. Both signs of the 12-bit offset in each format are covered, and the random addresses are spread over a window of a few hundred bytes, so stores and later loads overlap in many byte patterns.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned INSN_W = 32;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_FIN} lsu_state_e;
  typedef enum logic [1:0] {SZ_B, SZ_H, SZ_W, SZ_D} acc_size_e;

  typedef struct packed {
    logic      ld;
    logic      st;
    acc_size_e size;
    logic      sext;
    logic [4:0] rd;
  } acc_ctl_t;
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [INSN_W-1:0] insn,
  input  logic [ADDR_W-1:0] base,
  output acc_ctl_t          ctl,
  output logic [ADDR_W-1:0] addr
);
  logic [6:0]  opc;
  logic [2:0]  f3;
  logic [11:0] off12;

  always_comb begin
    opc      = insn[6:0];
    f3       = insn[14:12];
    ctl.ld   = (opc == OPC_LOAD) && (f3 != 3'b111);
    ctl.st   = (opc == OPC_STORE) && !f3[2];
    ctl.size = acc_size_e'(f3[1:0]);
    ctl.sext = ~f3[2];
    ctl.rd   = insn[11:7];
    // store offset is split across two fields, load offset is contiguous
    off12    = (opc == OPC_STORE) ? {insn[31:25], insn[11:7]} : insn[31:20];
    addr     = base + {{(ADDR_W-12){off12[11]}}, off12};
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]           wdata,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  acc_size_e                   size,
  output logic [2*DATA_W-1:0]         lanes,
  output logic [2*(DATA_W/8)-1:0]     be
);
  localparam int unsigned NB = DATA_W / 8;

  logic [NB-1:0]     raw_be;
  logic [DATA_W-1:0] wmask;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      raw_be[i] = (32'(i) < (32'd1 << size));
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_mask
    assign wmask[b*8 +: 8] = {8{raw_be[b]}};
  end

  // two words of lanes: bytes past the first word spill into the upper half
  assign be    = {{NB{1'b0}}, raw_be} << off;
  assign lanes = {{DATA_W{1'b0}}, wdata & wmask} << {off, 3'b000};
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge
  import lsu_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic [DATA_W-1:0]           lo,
  input  logic [DATA_W-1:0]           hi,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  acc_size_e                   size,
  input  logic                        sext,
  output logic [DATA_W-1:0]           res
);
  logic [2*DATA_W-1:0] joined;
  logic [DATA_W-1:0]   win;

  always_comb begin
    joined = {hi, lo} >> {off, 3'b000};
    win    = joined[DATA_W-1:0];
    unique case (size)
      SZ_B:    res = {{(DATA_W-8){sext & win[7]}}, win[7:0]};
      SZ_H:    res = {{(DATA_W-16){sext & win[15]}}, win[15:0]};
      SZ_W:    res = {{(DATA_W-32){sext & win[31]}}, win[31:0]};
      default: res = win;
    endcase
  end
endmodule

// File: rtl/lsu_top.sv
module lsu_top
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned DATA_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [31:0]           req_insn,
  input  logic [ADDR_W-1:0]     req_base,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_be,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  ld_valid,
  output logic [4:0]            ld_rd,
  output logic [DATA_W-1:0]     ld_data
);
  localparam int unsigned NB    = DATA_W / 8;
  localparam int unsigned OFF_W = $clog2(NB);
  localparam int unsigned WA_W  = ADDR_W - OFF_W;
  localparam int unsigned SP_W  = OFF_W + 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  acc_ctl_t            dec_ctl;
  logic [ADDR_W-1:0]   dec_addr;
  logic [2*DATA_W-1:0] al_lanes;
  logic [2*NB-1:0]     al_be;
  logic [SP_W-1:0]     span;
  logic                cross_d;
  logic                go;

  lsu_decode #(.ADDR_W(ADDR_W)) u_dec (
    .insn (req_insn),
    .base (req_base),
    .ctl  (dec_ctl),
    .addr (dec_addr)
  );

  lsu_lane_align #(.DATA_W(DATA_W)) u_align (
    .wdata (req_wdata),
    .off   (dec_addr[OFF_W-1:0]),
    .size  (dec_ctl.size),
    .lanes (al_lanes),
    .be    (al_be)
  );

  always_comb begin
    span    = SP_W'(dec_addr[OFF_W-1:0]) + (SP_W'(1) << dec_ctl.size);
    cross_d = span > SP_W'(NB);
  end

  lsu_state_e          state_q, state_d;
  acc_ctl_t            ctl_q;
  logic                cross_q;
  logic [WA_W-1:0]     waddr_q;
  logic [OFF_W-1:0]    off_q;
  logic [2*DATA_W-1:0] lanes_q;
  logic [2*NB-1:0]     be_q;
  logic [DATA_W-1:0]   lo_buf_q;
  logic [DATA_W-1:0]   res_q;
  logic [4:0]          res_rd_q;
  logic                ld_valid_q;
  logic [DATA_W-1:0]   merged;
  logic                cap_en, lo_en, res_en, hi_sel;

  assign req_ready = (state_q == ST_IDLE);
  assign go        = req_valid && req_ready && (dec_ctl.ld || dec_ctl.st);
  assign cap_en    = go;
  assign lo_en     = (state_q == ST_HI) && ctl_q.ld;
  assign res_en    = (state_q == ST_FIN);
  assign hi_sel    = (state_q == ST_HI);

  // next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = ST_LO;
      ST_LO:   state_d = cross_q ? ST_HI : (ctl_q.st ? ST_IDLE : ST_FIN);
      ST_HI:   state_d = ctl_q.st ? ST_IDLE : ST_FIN;
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q    <= ST_IDLE;
      ctl_q      <= '0;
      cross_q    <= 1'b0;
      ld_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      ld_valid_q <= res_en;
      if (cap_en) begin
        ctl_q   <= dec_ctl;
        cross_q <= cross_d;
      end
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      waddr_q <= dec_addr[ADDR_W-1:OFF_W];
      off_q   <= dec_addr[OFF_W-1:0];
      lanes_q <= al_lanes;
      be_q    <= al_be;
    end
    if (lo_en) lo_buf_q <= mem_rdata;
    if (res_en) begin
      res_q    <= merged;
      res_rd_q <= ctl_q.rd;
    end
  end

  // memory port
  always_comb begin
    mem_req   = (state_q == ST_LO) || (state_q == ST_HI);
    mem_we    = mem_req && ctl_q.st;
    mem_addr  = {waddr_q + WA_W'(hi_sel), {OFF_W{1'b0}}};
    mem_be    = mem_we ? (hi_sel ? be_q[2*NB-1:NB] : be_q[NB-1:0]) : '0;
    mem_wdata = hi_sel ? lanes_q[2*DATA_W-1:DATA_W] : lanes_q[DATA_W-1:0];
  end

  lsu_load_merge #(.DATA_W(DATA_W)) u_merge (
    .lo   (cross_q ? lo_buf_q : mem_rdata),
    .hi   (mem_rdata),
    .off  (off_q),
    .size (ctl_q.size),
    .sext (ctl_q.sext),
    .res  (merged)
  );

  assign ld_valid = ld_valid_q;
  assign ld_rd    = res_rd_q;
  assign ld_data  = res_q;

  // R9: no new request taken while a transaction is on the port
  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> !req_ready);

  // R9: a load result lasts one cycle
  p_result_pulse_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    ld_valid |=> !ld_valid);

  // R7: back-to-back transactions walk to the next doubleword
  p_upper_follows_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && $past(mem_req)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(NB)));

  // R8: a store confined to one word enables exactly its own byte count
  p_store_lanes_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_we && !cross_q) |-> ($countones(mem_be) == (1 << ctl_q.size)));

  // R6: a result follows a read issued two cycles earlier
  p_result_after_read_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    ld_valid |-> ($past(mem_req, 2) && !$past(mem_we, 2)));

  // R10: an accepted instruction that is not a legal access leaves the port idle
  p_noop_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sn)
    ($past(req_valid && req_ready) && !$past(go)) |-> !mem_req);

  // R12: the port only ever sees doubleword-aligned addresses
  p_aligned_r12: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));
endmodule

// File: tb/lsu_top_tb.sv
module lsu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_insn;
  logic [63:0] req_base;
  logic [63:0] req_wdata;
  logic        mem_req, mem_we;
  logic [63:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata;
  logic [63:0] mem_rdata;
  logic        ld_valid;
  logic [4:0]  ld_rd;
  logic [63:0] ld_data;

  always #2 clk = ~clk;  // 250 MHz

  lsu_top u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_insn(req_insn),
    .req_base(req_base), .req_wdata(req_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_rd(ld_rd), .ld_data(ld_data)
  );

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  endtask

  // memory behind the port and the bench's own picture of it
  bit [7:0] sys_mem [bit [63:0]];
  bit [7:0] ref_mem [bit [63:0]];
  logic [63:0] rdata_r;
  assign mem_rdata = rdata_r;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        for (int b = 0; b < 8; b++)
          if (mem_be[b]) sys_mem[mem_addr + 64'(b)] = mem_wdata[8*b +: 8];
      end else begin
        logic [63:0] w;
        for (int b = 0; b < 8; b++) w[8*b +: 8] = sys_mem[mem_addr + 64'(b)];
        rdata_r <= w;
      end
    end
  end

  function automatic logic [63:0] ea_of(logic [31:0] i, logic [63:0] b);
    logic [11:0] o;
    o = (i[6:0] == 7'b0100011) ? {i[31:25], i[11:7]} : i[31:20];
    return b + {{52{o[11]}}, o};
  endfunction

  function automatic logic [31:0] enc_ld(logic [2:0] f3, logic [4:0] rd, logic [11:0] imm);
    return {imm, 5'd22, f3, rd, 7'b0000011};
  endfunction

  function automatic logic [31:0] enc_st(logic [2:0] f3, logic [11:0] imm);
    return {imm[11:5], 5'd9, 5'd22, f3, imm[4:0], 7'b0100011};
  endfunction

  // reference model, stepped on every falling edge
  bit          rst_done = 0;
  bit          took = 0;
  int          bcnt = 0, txcnt = 0, ldcnt = 0, txidx = 0;
  logic [63:0] tx_addr;
  bit          tx_we;
  logic [63:0] exp_data_q[$];
  logic [4:0]  exp_rd_q[$];
  string       exp_tag_q[$];

  task automatic model_accept();
    logic [6:0]  opc;
    logic [2:0]  f3;
    logic [63:0] ea, v;
    int          n, ntx;
    opc = req_insn[6:0];
    f3  = req_insn[14:12];
    ea  = ea_of(req_insn, req_base);
    n   = 1 << f3[1:0];
    ntx = (int'(ea[2:0]) + n > 8) ? 2 : 1;
    took = 1;
    if (opc == 7'b0000011 && f3 != 3'b111) begin
      v = '0;
      for (int i = 0; i < n; i++) v[8*i +: 8] = ref_mem[ea + 64'(i)];
      if (!f3[2] && n < 8 && v[8*n-1])
        for (int i = 8*n; i < 64; i++) v[i] = 1'b1;
      exp_data_q.push_back(v);
      exp_rd_q.push_back(req_insn[11:7]);
      exp_tag_q.push_back(ntx == 2 ? "R7" : (!f3[2] && n < 8) ? "R5" : "R4");
      ldcnt = 3 + ntx; bcnt = 1 + ntx; txcnt = ntx; txidx = 0;
      tx_addr = {ea[63:3], 3'b000}; tx_we = 0;
    end else if (opc == 7'b0100011 && !f3[2]) begin
      for (int i = 0; i < n; i++) ref_mem[ea + 64'(i)] = req_wdata[8*i +: 8];
      bcnt = ntx; txcnt = ntx; txidx = 0;
      tx_addr = {ea[63:3], 3'b000}; tx_we = 1;
    end
  endtask

  always @(negedge clk) begin
    if (rst_done) begin
      bit exp_rdy, exp_mem, exp_v;
      exp_rdy = (bcnt == 0);
      chk(req_ready == exp_rdy, "R9 ready", 64'(req_ready), 64'(exp_rdy));
      exp_mem = (txcnt > 0);
      chk(mem_req == exp_mem, "R6 mem_req", 64'(mem_req), 64'(exp_mem));
      if (exp_mem && mem_req) begin
        chk(mem_addr == tx_addr, txidx == 1 ? "R7 addr" : (tx_we ? "R3 addr" : "R2 addr"),
            mem_addr, tx_addr);
        chk(mem_we == tx_we, "R3 we", 64'(mem_we), 64'(tx_we));
      end
      if (ldcnt > 0) ldcnt--;
      exp_v = (ldcnt == 1);
      chk(ld_valid == exp_v, "R9 ld_valid", 64'(ld_valid), 64'(exp_v));
      if (exp_v && ld_valid && exp_data_q.size() > 0) begin
        logic [63:0] ed;
        logic [4:0]  er;
        string       et;
        ed = exp_data_q.pop_front();
        er = exp_rd_q.pop_front();
        et = exp_tag_q.pop_front();
        chk(ld_data == ed, et, ld_data, ed);
        chk(ld_rd == er, "R11 rd", 64'(ld_rd), 64'(er));
      end
      if (bcnt > 0) bcnt--;
      if (txcnt > 0) begin
        txcnt--; txidx++; tx_addr = tx_addr + 64'd8;
      end
      if (exp_rdy && req_valid) model_accept();
    end
  end

  // compare the bytes around a store target; R8 for legal stores, R10 otherwise
  task automatic cmp_region(logic [63:0] ea, string tag);
    bit ok = 1;
    logic [63:0] g = '0, e = '0;
    for (int i = -8; i < 16; i++) begin
      logic [63:0] a;
      a = ea + 64'(signed'(i));
      if (ok && sys_mem[a] != ref_mem[a]) begin
        ok = 0; g = 64'(sys_mem[a]); e = 64'(ref_mem[a]);
      end
    end
    chk(ok, tag, g, e);
  endtask

  task automatic do_op(logic [31:0] insn, logic [63:0] base, logic [63:0] wd);
    @(posedge clk); #1;
    req_insn = insn; req_base = base; req_wdata = wd; req_valid = 1; took = 0;
    forever begin
      @(posedge clk);
      if (took) break;
    end
    #1 req_valid = 0;
    while (bcnt != 0 || ldcnt != 0) @(posedge clk);
    @(posedge clk); #1;
    if (insn[6:0] == 7'b0100011)
      cmp_region(ea_of(insn, base), insn[14] ? "R10 store ignored" : "R8 store bytes");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R9: watchdog expired, got 0 expected 1");
    report();
  end

  localparam logic [63:0] B = 64'h1000;

  initial begin
    for (int a = 'h0F00; a < 'h1300; a++) begin
      sys_mem[64'(a)] = 8'(a * 37 + 5);
      ref_mem[64'(a)] = 8'(a * 37 + 5);
    end
    rdata_r = '0;
    req_valid = 0; req_insn = '0; req_base = '0; req_wdata = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", 64'(req_ready), 64'd1);
    chk(mem_req == 1'b0, "R1 mem_req", 64'(mem_req), 64'd0);
    chk(ld_valid == 1'b0, "R1 ld_valid", 64'(ld_valid), 64'd0);
    rst_done = 1;

    // R8/R4: aligned doubleword store and load back
    do_op(enc_st(3'b011, 12'd0), B, 64'h8877665544332211);
    do_op(enc_ld(3'b011, 5'd9, 12'd0), B, '0);
    // R2: doubleword at +64 from the base
    do_op(enc_ld(3'b011, 5'd9, 12'd64), B, '0);
    // R5: byte 0xF7 signed and unsigned
    do_op(enc_st(3'b000, 12'd16), B, 64'h00000000000000F7);
    do_op(enc_ld(3'b000, 5'd5, 12'd16), B, '0);
    do_op(enc_ld(3'b100, 5'd6, 12'd16), B, '0);
    // R7: halfword across a boundary
    do_op(enc_st(3'b001, 12'd7), B, 64'h000000000000BEEF);
    do_op(enc_ld(3'b001, 5'd7, 12'd7), B, '0);
    do_op(enc_ld(3'b101, 5'd8, 12'd7), B, '0);
    // R7: word and doubleword across a boundary
    do_op(enc_st(3'b010, 12'h025), B, 64'h00000000CAFE8001);
    do_op(enc_ld(3'b010, 5'd10, 12'h025), B, '0);
    do_op(enc_ld(3'b110, 5'd11, 12'h025), B, '0);
    do_op(enc_st(3'b011, 12'h033), B, 64'hF0E1D2C3B4A59687);
    do_op(enc_ld(3'b011, 5'd12, 12'h033), B, '0);
    // R2/R3: negative offsets
    do_op(enc_ld(3'b011, 5'd13, 12'hFF8), B + 64'h80, '0);
    do_op(enc_st(3'b001, 12'hFCE), B + 64'h80, 64'h0000000000009A5C);
    do_op(enc_ld(3'b001, 5'd14, 12'hFCE), B + 64'h80, '0);
    // R10: undefined widths and a non-memory instruction
    do_op(enc_ld(3'b111, 5'd15, 12'd8), B, '0);
    do_op(enc_st(3'b100, 12'd8), B, 64'hFFFFFFFFFFFFFFFF);
    do_op(32'h015A04B3, B, '0);
    do_op(enc_ld(3'b011, 5'd16, 12'd8), B, '0);

    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0]  f3;
      logic [11:0] imm;
      logic [63:0] base, wd;
      int          sel;
      f3   = 3'($urandom_range(0, 7));
      imm  = 12'($urandom_range(0, 255)) - 12'd128;
      base = B + 64'($urandom_range(0, 255));
      wd   = {$urandom, $urandom};
      sel  = $urandom_range(0, 9);
      if (sel < 5)      do_op(enc_ld(f3, 5'($urandom_range(0, 31)), imm), base, wd);
      else if (sel < 9) do_op(enc_st(f3 & 3'b011, imm), base, wd);
      else              do_op(32'h015A04B3, base, wd);
    end
    repeat (4) @(posedge clk);
    report();
  end
endmodule